// File: doc/BRIEF.md
# Fixed-Rate Asynchronous Serial Port (8/9-bit)

This block is a full-duplex asynchronous serial port for a low-power controller. Its bit timing comes from a 76.8 kHz reference, made inside the block by dividing the system clock by `REF_DIV`. A single speed input picks one of two rates. At 4800 bit/s each bit lasts 16 reference periods. At 9600 bit/s each bit lasts 8 reference periods. A 2-bit format field picks frames with 8 data bits or 9 data bits.

Software starts a transmission by writing the buffer. The received byte is read from a separate holding register. A read strobe marks that byte as consumed. Received frames are double-buffered: a frame that completes while the previous byte is still unread is dropped. The transmit-done flag and the receive-done flag are set by hardware. Each flag stays set until software clears it with its own pulse input. A receive enable gates start-bit detection.

Top module: `uart_fixed`

## Requirements
- R1: The format field `mode` selects the frame: 2'b10 means 8 data bits and 2'b01 means 9 data bits. With 2'b00 or 2'b11, a buffer write starts no frame and falling edges on `rxd` start no reception.
- R2: The bit time is 16 reference periods when `fast`=0 and 8 reference periods when `fast`=1. One reference period is `REF_DIV` clocks. Because the divider runs freely, the first bit sent after a write may be up to `REF_DIV`-1 clocks short.
- R3: Each transmitted frame is sent in this order: a start bit of 0, the data bits LSB first, then in 9-bit mode the value of `tx_bit9`, then a stop bit of 1. `txd` is 1 whenever no frame is in progress.
- R4: A `wr_buf` pulse while the transmitter is idle starts a frame with `wr_data`. `txd` goes to 0 on the following clock. A `wr_buf` pulse while a frame is in progress is ignored.
- R5: `tx_flag` becomes 1 on the clock where the stop bit starts on `txd`. It stays 1 until a `clr_tx_flag` pulse.
- R6: `rxd` passes through a two-flop synchronizer. A falling edge starts a frame, and each bit is sampled at mid-bit. The data bits, LSB first, appear on `rd_data` when the frame is accepted.
- R7: When a frame is accepted in 8-bit mode, `rx_bit8` takes the sampled stop-bit value. In 9-bit mode it takes the ninth data bit, and the stop bit is ignored, so a frame whose stop bit is 0 is still accepted.
- R8: `rx_flag` becomes 1 at the mid-bit sample of the stop bit (a few clocks of synchronizer delay later). It stays 1 until a `clr_rx_flag` pulse.
- R9: While `rx_en`=0, no reception starts.
- R10: If the start bit reads 1 at its mid-bit sample, the frame is abandoned and the receiver returns to waiting for a falling edge.
- R11: A frame that completes before `rd_buf` has been pulsed since the last accepted byte is discarded. `rd_data` and `rx_bit8` keep their values and `rx_flag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Frame format select |
| fast | input | 1 | Speed select, 1 = 8 reference periods per bit |
| rx_en | input | 1 | Receive enable |
| tx_bit9 | input | 1 | Ninth transmit bit for 9-bit mode |
| wr_buf | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_buf | input | 1 | Buffer read strobe, marks the held byte as consumed |
| clr_tx_flag | input | 1 | Clears the transmit-done flag |
| clr_rx_flag | input | 1 | Clears the receive-done flag |
| rxd | input | 1 | Serial input (asynchronous) |
| txd | output | 1 | Serial output |
| tx_flag | output | 1 | Transmit-done flag |
| rx_flag | output | 1 | Receive-done flag |
| rd_data | output | 8 | Receive holding register |
| rx_bit8 | output | 1 | Stop bit or ninth data bit of the accepted frame |

## Verification
The bench builds the block with `REF_DIV`=2, so one reference period is two system clocks. A bit therefore lasts 32 clocks at the slow rate and 16 at the fast rate, and complete frames at both rates fit into a short run. With this value the divider phase still varies at each write, so the short first bit allowed by R2 occurs. The synchronizer delay then becomes a noticeable fraction of a bit, which tests the mid-bit sample point and the flag timing tightly at the fast rate.

// File: rtl/uart_pkg.sv
// Shared types and helpers for the fixed-rate serial port.
// Assumes the reference divider produces a 76.8 kHz tick.
package uart_pkg;
    typedef enum logic [1:0] {
        FMT_OFF0  = 2'b00,
        FMT_NINE  = 2'b01,
        FMT_EIGHT = 2'b10,
        FMT_OFF3  = 2'b11
    } fmt_e;

    localparam int OSR_SLOW = 16;
    localparam int OSR_FAST = 8;
    localparam int OS_W     = $clog2(OSR_SLOW);
    localparam int IDX_W    = 4;

    // True for the two supported frame formats.
    function automatic logic fmt_ok(input logic [1:0] m);
        return (m == FMT_NINE) || (m == FMT_EIGHT);
    endfunction

    // Last oversampling count of a bit for the selected speed.
    function automatic logic [OS_W-1:0] os_last(input logic fast);
        return fast ? OS_W'(OSR_FAST - 1) : OS_W'(OSR_SLOW - 1);
    endfunction

    // Count at which a bit is at its midpoint.
    function automatic logic [OS_W-1:0] os_half(input logic fast);
        return fast ? OS_W'(OSR_FAST/2 - 1) : OS_W'(OSR_SLOW/2 - 1);
    endfunction
endpackage

// File: rtl/uart_refclk.sv
// Reference tick generator: emits a one-clock pulse every REF_DIV clocks.
// Assumes REF_DIV >= 1; the tick is free running and not tied to frames.
module uart_refclk #(
    parameter int REF_DIV = 651
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(REF_DIV - 1);

    logic [CW-1:0] cnt;

    // Free-running divider with a registered terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            cnt  <= (cnt == CNT_LAST) ? '0 : cnt + CW'(1);
            tick <= (cnt == CNT_LAST);
        end
    end
endmodule

// File: rtl/uart_tx.sv
// Transmit shifter: sends start, 8 or 9 data bits LSB first, then stop.
// Assumes tick is one reference period; bit length is set by osr_last.
module uart_tx
    import uart_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [OS_W-1:0] osr_last,
    input  logic            load,
    input  logic            nine,
    input  logic            bit9,
    input  logic [7:0]      data,
    output logic            txd,
    output logic            busy,
    output logic            stop_start
);
    logic [10:0]      sh;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last;
    logic [OS_W-1:0]  os;
    logic             bit_end;

    assign bit_end    = busy && tick && (os >= osr_last);
    assign stop_start = bit_end && (idx + IDX_W'(1) == last);
    assign txd        = busy ? sh[0] : 1'b1;

    // Frame load, per-bit timing and shifting of the outgoing frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sh   <= '1;
            idx  <= '0;
            last <= IDX_W'(9);
            os   <= '0;
        end else if (!busy) begin
            if (load) begin
                busy <= 1'b1;
                sh   <= {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
                idx  <= '0;
                last <= nine ? IDX_W'(10) : IDX_W'(9);
                os   <= '0;
            end
        end else if (tick) begin
            if (bit_end) begin
                os <= '0;
                if (idx == last) begin
                    busy <= 1'b0;
                end else begin
                    idx <= idx + IDX_W'(1);
                    sh  <= {1'b1, sh[10:1]};
                end
            end else begin
                os <= os + OS_W'(1);
            end
        end
    end
endmodule

// File: rtl/uart_rx.sv
// Receive sampler: synchronizes rxd, detects the start edge, samples each
// bit at mid-bit and reports a completed frame with a one-clock pulse.
// Assumes the caller decides whether a completed frame is kept.
module uart_rx
    import uart_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [OS_W-1:0] osr_last,
    input  logic [OS_W-1:0] half_last,
    input  logic            enable,
    input  logic            nine,
    input  logic            rxd,
    output logic            busy,
    output logic            done,
    output logic [7:0]      done_data,
    output logic            done_b8
);
    logic             s1, s2, s3;
    logic             fall;
    logic             sample;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last;
    logic [OS_W-1:0]  os;
    logic [8:0]       sh;
    logic [8:0]       sh_nxt;

    // Two-flop synchronizer plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) {s1, s2, s3} <= 3'b111;
        else        {s1, s2, s3} <= {rxd, s1, s2};
    end

    assign fall   = s3 && !s2;
    assign sample = busy && tick && (os == half_last);

    // Next shift content: data positions shift in, start and stop do not.
    always_comb begin
        sh_nxt = sh;
        if (idx != '0 && idx <= IDX_W'(9)) sh_nxt = {s2, sh[8:1]};
    end

    assign done      = sample && (idx == last);
    assign done_data = sh_nxt[7:0];
    assign done_b8   = sh_nxt[8];

    // Frame tracking: start on an edge, abandon on a false start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            last <= IDX_W'(9);
            os   <= '0;
            sh   <= '0;
        end else if (!busy) begin
            if (enable && fall) begin
                busy <= 1'b1;
                idx  <= '0;
                last <= nine ? IDX_W'(10) : IDX_W'(9);
                os   <= '0;
            end
        end else if (tick) begin
            if (sample) begin
                sh <= sh_nxt;
                if ((idx == '0 && s2) || idx == last) busy <= 1'b0;
            end
            if (os >= osr_last) begin
                os  <= '0;
                idx <= idx + IDX_W'(1);
            end else begin
                os <= os + OS_W'(1);
            end
        end
    end
endmodule

// File: rtl/uart_fixed.sv
// Fixed-rate 8/9-bit serial port top: reference divider, transmitter,
// receiver, sticky flags and the receive holding register.
// Assumes synchronous active-low reset and single-cycle strobes.
module uart_fixed
    import uart_pkg::*;
#(
    parameter int REF_DIV = 651
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       fast,
    input  logic       rx_en,
    input  logic       tx_bit9,
    input  logic       wr_buf,
    input  logic [7:0] wr_data,
    input  logic       rd_buf,
    input  logic       clr_tx_flag,
    input  logic       clr_rx_flag,
    input  logic       rxd,
    output logic       txd,
    output logic       tx_flag,
    output logic       rx_flag,
    output logic [7:0] rd_data,
    output logic       rx_bit8
);
    logic            tick;
    logic            tx_busy, tx_stop;
    logic            rx_busy, rx_done, rx_b8_new;
    logic [7:0]      rx_data_new;
    logic            rx_unread;
    logic [OS_W-1:0] osr_last, half_last;
    logic            nine;

    assign osr_last  = os_last(fast);
    assign half_last = os_half(fast);
    assign nine      = (mode == FMT_NINE);

    uart_refclk #(.REF_DIV(REF_DIV)) u_ref (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .osr_last(osr_last),
        .load(wr_buf && fmt_ok(mode)), .nine(nine), .bit9(tx_bit9),
        .data(wr_data), .txd(txd), .busy(tx_busy), .stop_start(tx_stop)
    );

    uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .osr_last(osr_last),
        .half_last(half_last), .enable(rx_en && fmt_ok(mode)), .nine(nine),
        .rxd(rxd), .busy(rx_busy), .done(rx_done),
        .done_data(rx_data_new), .done_b8(rx_b8_new)
    );

    // Transmit flag: set at stop-bit start, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)          tx_flag <= 1'b0;
        else if (tx_stop)    tx_flag <= 1'b1;
        else if (clr_tx_flag) tx_flag <= 1'b0;
    end

    // Holding register, unread marker and receive flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            rx_bit8   <= 1'b0;
            rx_unread <= 1'b0;
            rx_flag   <= 1'b0;
        end else begin
            if (rx_done && !rx_unread) begin
                rd_data   <= rx_data_new;
                rx_bit8   <= rx_b8_new;
                rx_unread <= 1'b1;
                rx_flag   <= 1'b1;
            end else begin
                if (rd_buf)      rx_unread <= 1'b0;
                if (clr_rx_flag) rx_flag   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_fixed_chk.sv
// Property checker for uart_fixed, attached with bind below.
// Assumes it sees the top's ports and its internal busy/unread state.
module uart_fixed_chk
    import uart_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       rx_en,
    input logic       wr_buf,
    input logic       clr_tx_flag,
    input logic       clr_rx_flag,
    input logic       rd_buf,
    input logic       txd,
    input logic       tx_flag,
    input logic       rx_flag,
    input logic [7:0] rd_data,
    input logic       rx_bit8,
    input logic       tx_busy,
    input logic       rx_busy,
    input logic       rx_unread
);
    p_write_starts_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_buf && fmt_ok(mode) && !tx_busy) |=> (tx_busy && !txd));

    p_bad_mode_no_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt_ok(mode) && !tx_busy) |=> !tx_busy);

    p_bad_mode_no_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt_ok(mode) && !rx_busy) |=> !rx_busy);

    p_tx_flag_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flag) |-> (tx_busy && txd));

    p_tx_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flag && !clr_tx_flag) |=> tx_flag);

    p_rx_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !clr_rx_flag) |=> rx_flag);

    p_rx_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rx_busy) |=> !rx_busy);

    p_unread_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_unread && !rd_buf) |=> ($stable(rd_data) && $stable(rx_bit8)));
endmodule

bind uart_fixed uart_fixed_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_en(rx_en), .wr_buf(wr_buf),
    .clr_tx_flag(clr_tx_flag), .clr_rx_flag(clr_rx_flag), .rd_buf(rd_buf),
    .txd(txd), .tx_flag(tx_flag), .rx_flag(rx_flag), .rd_data(rd_data),
    .rx_bit8(rx_bit8), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .rx_unread(rx_unread)
);

// File: tb/sim_uart_fixed.sv
// Self-checking bench for uart_fixed: directed corners plus seeded random frames.
module sim_uart_fixed;
    localparam int REF_DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b10;
    logic       fast = 1'b0;
    logic       rx_en = 1'b1;
    logic       tx_bit9 = 1'b0;
    logic       wr_buf = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_buf = 1'b0;
    logic       clr_tx_flag = 1'b0;
    logic       clr_rx_flag = 1'b0;
    logic       rxd = 1'b1;
    logic       txd, tx_flag, rx_flag, rx_bit8;
    logic [7:0] rd_data;

    int errs = 0;
    int checks = 0;
    bit finished = 0;
    logic pre_flag;

    always #10 clk = ~clk;

    uart_fixed #(.REF_DIV(REF_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .fast(fast), .rx_en(rx_en),
        .tx_bit9(tx_bit9), .wr_buf(wr_buf), .wr_data(wr_data), .rd_buf(rd_buf),
        .clr_tx_flag(clr_tx_flag), .clr_rx_flag(clr_rx_flag), .rxd(rxd),
        .txd(txd), .tx_flag(tx_flag), .rx_flag(rx_flag), .rd_data(rd_data),
        .rx_bit8(rx_bit8)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bit_clks(input logic f);
        return (f ? 8 : 16) * REF_DIV;
    endfunction

    function automatic logic [10:0] frame_of(input logic [7:0] d, input logic b9, input logic nn);
        return {1'b1, (nn ? b9 : 1'b1), d, 1'b0};
    endfunction

    // Transmit one frame and check the line at each mid-bit (R3, R2, R5, R4).
    task automatic do_tx(input logic [1:0] m, input logic f, input logic [7:0] d,
                         input logic b9, input bit busy_wr);
        int p, n, c;
        logic nn;
        logic [10:0] got, exp;
        p = bit_clks(f);
        nn = (m == 2'b01);
        n = nn ? 11 : 10;
        got = '1;
        @(negedge clk);
        mode = m; fast = f; tx_bit9 = b9; wr_data = d; wr_buf = 1'b1; clr_tx_flag = 1'b1;
        @(negedge clk);
        wr_buf = 1'b0; clr_tx_flag = 1'b0;
        c = 1;
        for (int k = 0; k < n; k++) begin
            repeat (k*p + p/2 - c) @(negedge clk);
            c = k*p + p/2;
            got[k] = txd;
            if (k == n-2) chk(tx_flag == 1'b0, "R5 flag before stop", tx_flag, 0);
            if (k == n-1) chk(tx_flag == 1'b1, "R5 flag in stop", tx_flag, 1);
            if (busy_wr && k == 3) begin
                wr_data = ~d; wr_buf = 1'b1;
                @(negedge clk);
                wr_buf = 1'b0;
                c++;
            end
        end
        exp = frame_of(d, b9, nn);
        if (!nn) begin got[10] = 1'b1; exp[10] = 1'b1; end
        chk(got == exp, "R3 tx frame", int'(got), int'(exp));
        repeat (n*p - c + 4) @(negedge clk);
        begin
            int lows = 0;
            for (int i = 0; i < p; i++) begin
                if (!txd) lows++;
                @(negedge clk);
            end
            chk(lows == 0, busy_wr ? "R4 write while busy ignored" : "R3 idle high", lows, 0);
        end
    endtask

    // Drive one frame on rxd; records rx_flag a quarter into the stop bit.
    task automatic send_frame(input logic f, input logic nn, input logic [7:0] d,
                              input logic b9, input logic stopv);
        int p;
        logic [10:0] fr;
        p = bit_clks(f);
        fr = {stopv, (nn ? b9 : stopv), d, 1'b0};
        for (int k = 0; k < (nn ? 11 : 10); k++) begin
            rxd = fr[k];
            if (k == (nn ? 10 : 9)) begin
                repeat (p/4) @(negedge clk);
                pre_flag = rx_flag;
                repeat (p - p/4) @(negedge clk);
            end else begin
                repeat (p) @(negedge clk);
            end
        end
        rxd = 1'b1;
        repeat (p) @(negedge clk);
    endtask

    task automatic release_buf(input bit do_read);
        @(negedge clk);
        rd_buf = do_read; clr_rx_flag = 1'b1;
        @(negedge clk);
        rd_buf = 1'b0; clr_rx_flag = 1'b0;
    endtask

    // Receive one frame with a cleared, read buffer and check it (R6, R7, R8).
    task automatic rx_case(input logic [1:0] m, input logic f, input logic [7:0] d,
                           input logic b9, input logic stopv);
        logic nn;
        nn = (m == 2'b01);
        mode = m; fast = f;
        release_buf(1);
        send_frame(f, nn, d, b9, stopv);
        chk(pre_flag == 1'b0, "R8 flag not before mid-stop", pre_flag, 0);
        chk(rx_flag == 1'b1, "R8 flag after mid-stop", rx_flag, 1);
        chk(rd_data == d, "R6 received byte", rd_data, d);
        chk(rx_bit8 == (nn ? b9 : stopv), "R7 ninth/stop bit", rx_bit8, nn ? b9 : stopv);
    endtask

    // Measure the low time of the start bit (R2).
    task automatic measure_start(input logic f);
        int len, p;
        p = bit_clks(f);
        len = 0;
        @(negedge clk);
        mode = 2'b10; fast = f; wr_data = 8'hFF; wr_buf = 1'b1;
        @(negedge clk);
        wr_buf = 1'b0;
        while (!txd && len < 4*p) begin
            len++;
            @(negedge clk);
        end
        chk(len >= p - REF_DIV + 1 && len <= p, "R2 start bit length", len, p);
        repeat (10*p) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R3 reset line high", txd, 1);
        chk(tx_flag == 1'b0 && rx_flag == 1'b0, "R5 R8 reset flags", {tx_flag, rx_flag}, 0);
        chk(rd_data == 8'h00 && rx_bit8 == 1'b0, "R6 reset holding", rd_data, 0);

        // Rate and transmit shape
        measure_start(1'b0);
        measure_start(1'b1);
        do_tx(2'b10, 1'b0, 8'hA5, 1'b0, 0);
        do_tx(2'b01, 1'b1, 8'h3C, 1'b1, 0);
        do_tx(2'b01, 1'b0, 8'hC3, 1'b0, 0);
        do_tx(2'b10, 1'b1, 8'h55, 1'b0, 1);

        // R1 unsupported codes: no transmit, no receive
        begin
            int lows = 0;
            @(negedge clk);
            mode = 2'b00; fast = 1'b0; wr_data = 8'h00; wr_buf = 1'b1;
            @(negedge clk);
            wr_buf = 1'b0;
            for (int i = 0; i < 10*bit_clks(1'b0); i++) begin
                if (!txd) lows++;
                @(negedge clk);
            end
            chk(lows == 0, "R1 mode 00 no transmit", lows, 0);
        end
        rx_case(2'b10, 1'b0, 8'h81, 1'b0, 1'b1);
        mode = 2'b11;
        release_buf(1);
        send_frame(1'b0, 1'b0, 8'h7E, 1'b0, 1'b1);
        chk(rx_flag == 1'b0 && rd_data == 8'h81, "R1 mode 11 no receive", rd_data, 8'h81);

        // R9 receive disabled
        mode = 2'b10;
        release_buf(1);
        rx_en = 1'b0;
        send_frame(1'b0, 1'b0, 8'h42, 1'b0, 1'b1);
        chk(rx_flag == 1'b0 && rd_data == 8'h81, "R9 disabled receiver", rd_data, 8'h81);
        rx_en = 1'b1;

        // R10 false start then a good frame
        release_buf(1);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bit_clks(1'b1)/4) @(negedge clk);
        fast = 1'b1;
        rxd = 1'b1;
        repeat (2*bit_clks(1'b1)) @(negedge clk);
        chk(rx_flag == 1'b0, "R10 glitch rejected", rx_flag, 0);
        rx_case(2'b10, 1'b1, 8'h96, 1'b0, 1'b1);

        // R7 stop bit of 0 in both formats
        rx_case(2'b01, 1'b1, 8'h5A, 1'b1, 1'b0);
        rx_case(2'b10, 1'b0, 8'hE1, 1'b0, 1'b0);

        // R11 overrun discard
        rx_case(2'b10, 1'b0, 8'h11, 1'b0, 1'b1);
        release_buf(0);
        send_frame(1'b0, 1'b0, 8'h22, 1'b0, 1'b1);
        chk(rx_flag == 1'b0, "R11 no flag on discard", rx_flag, 0);
        chk(rd_data == 8'h11, "R11 held byte kept", rd_data, 8'h11);
        rx_case(2'b10, 1'b0, 8'h33, 1'b0, 1'b1);

        // Seeded random frames both ways
        for (int i = 0; i < 10; i++) begin
            logic [1:0] m;
            logic f, b9;
            logic [7:0] d;
            m  = ($urandom % 2) ? 2'b10 : 2'b01;
            f  = 1'($urandom % 2);
            b9 = 1'($urandom % 2);
            d  = 8'($urandom);
            do_tx(m, f, d, b9, 0);
            rx_case(m, f, ~d, ~b9, 1'b1);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule